// File: doc/BRIEF.md
# Fieldbus Datagram Pass-Through Processor

This block sits in the receive-to-transmit path of a fieldbus slave. An Ethernet frame enters as a byte stream, one byte per beat, and leaves one clock later on an identical stream. Frames of any other type leave unchanged. If the EtherType is the fieldbus type, the block walks the chain of datagrams as the bytes pass. Each datagram that addresses this station and names a supported command is processed in place. A read fills its payload from a 256-byte local register array. A write copies its payload into the array. The datagram's working counter is lowered while it passes through.

A main-port status input applies the loop guard. When the main port is closed, the first datagram leaves with its circulating flag set. If that flag was already set on arrival, the frame is destroyed: the beat that carries the flag leaves with an abort strobe, and the rest of the frame is not forwarded.

Top module: `fbus_dgram_engine`

## Requirements
- R1: A frame whose bytes 12 and 13 are not 0x88, 0xA4 leaves byte for byte unchanged, with its start and end markers.
- R2: In a fieldbus frame, bytes 14 and 15 are a header that passes unchanged, and the first datagram starts at byte 16. Each datagram has this layout. Byte 0 is the command and byte 1 is the index. Bytes 2 to 5 are a little-endian address: bits 15:0 are the array offset and bits 31:16 are the station. Bytes 6 and 7 are little-endian: bits 10:0 are the payload length, bit 13 is the circulating flag and bit 15 is the more flag. Bytes 8 and 9 are the IRQ field. The payload follows, and then a little-endian 16-bit working counter.
- R3: Command 1 replaces each payload byte with the array byte at offset+k. Command 2 stores each payload byte at offset+k and forwards the payload unchanged. Command 3 does both: it sends out the old array byte and stores the incoming byte. Every other command code leaves the datagram and the array untouched.
- R4: A datagram is served only if its station field equals `station_addr` and offset+length is at most 256. Otherwise its payload, its counter and the array stay unchanged.
- R5: A served datagram's counter is lowered modulo 65536: by 1 for a write, by 2 for a read and by 3 for a read-write. The borrow carries from the low byte into the high byte.
- R6: Another datagram follows only when the more flag is set. Bytes after the last datagram pass unchanged.
- R7: With `main_port_open` low, no datagram is served. A first datagram whose circulating flag is clear leaves with bit 5 of its byte 7 set. Datagrams after the first are not altered.
- R8: With `main_port_open` low and the first datagram's circulating flag set on arrival, the output beat that carries that datagram's byte 7 has `out_abort` high. No further beat of that frame is output. The next frame is processed normally.
- R9: After reset all outputs are low, and array byte i holds i XOR 0xA5.
- R10: Every input beat with `in_valid` high leaves exactly one clock later. Idle cycles within a frame give idle output cycles and do not disturb parsing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| station_addr | input | 16 | Station this slave answers to |
| main_port_open | input | 1 | High while the main port is open |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_abort | output | 1 | Frame destroyed at this beat |

## Verification
Every result of this block is due on the output beat exactly one clock after the input beat that carries it. This covers a replaced payload byte, a lowered counter byte, a set circulating flag and the abort strobe. Array writes become visible to the next datagram that reads the same offset. The bench registers each beat's expected value at the same edge at which the design takes the input. It then compares the whole output tuple at the following falling edge, so idle gaps and back-to-back frames keep the same one-cycle alignment.

// File: rtl/fbus_dgram_engine.sv
module fbus_dgram_engine #(
  parameter int          DEPTH = 256,
  parameter logic [15:0] ETYPE = 16'h88A4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] station_addr,
  input  logic        main_port_open,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_sof,
  output logic        out_eof,
  output logic        out_abort
);
  localparam int PW   = $clog2(DEPTH);
  localparam int LENW = 11;

  typedef enum logic [2:0] {S_ETH, S_FHDR, S_DHDR, S_PAY, S_WKC, S_PASS, S_DROP} st_t;

  st_t            st, cst, nst;
  logic [LENW-1:0] cnt, ccnt, ncnt;
  logic [7:0]     cmd_q, len_lo_q, obyte;
  logic [15:0]    off_q, stn_q;
  logic [LENW-1:0] len_q, len_now;
  logic           et_hi_q, first_q, more_q, rd_q, wr_q, brw_q;
  logic [PW-1:0]  ptr_q;
  logic [7:0]     mem [DEPTH];
  logic [16:0]    end_addr;
  logic [1:0]     dec;
  logic           hdr7, destroy, mark, range_ok, cmd_ok, hit, in_pay, in_wkc0, in_wkc1;

  assign cst      = in_sof ? S_ETH : st;
  assign ccnt     = in_sof ? '0 : cnt;
  assign hdr7     = (cst == S_DHDR) && (ccnt == 11'd7);
  assign len_now  = {in_data[2:0], len_lo_q};
  assign destroy  = hdr7 && first_q && !main_port_open && in_data[5];
  assign mark     = hdr7 && first_q && !main_port_open && !in_data[5];
  assign end_addr = {1'b0, off_q} + {6'd0, len_now};
  assign range_ok = end_addr <= 17'(DEPTH);
  assign cmd_ok   = (cmd_q == 8'd1) || (cmd_q == 8'd2) || (cmd_q == 8'd3);
  assign hit      = main_port_open && (stn_q == station_addr) && cmd_ok && range_ok;
  assign in_pay   = (cst == S_PAY);
  assign in_wkc0  = (cst == S_WKC) && (ccnt == 11'd0);
  assign in_wkc1  = (cst == S_WKC) && (ccnt == 11'd1);
  assign dec      = {rd_q, wr_q};

  always_comb begin
    obyte = in_data;
    if (mark)                obyte = in_data | 8'h20;
    else if (in_pay && rd_q) obyte = mem[ptr_q];
    else if (in_wkc0)        obyte = in_data - {6'd0, dec};
    else if (in_wkc1)        obyte = in_data - {7'd0, brw_q};
  end

  always_comb begin
    nst  = cst;
    ncnt = ccnt + 11'd1;
    unique case (cst)
      S_ETH:  if (ccnt == 11'd13) begin
                ncnt = '0;
                nst  = (et_hi_q && in_data == ETYPE[7:0]) ? S_FHDR : S_PASS;
              end
      S_FHDR: if (ccnt == 11'd1) begin
                ncnt = '0;
                nst  = S_DHDR;
              end
      S_DHDR: if (destroy) begin
                ncnt = '0;
                nst  = S_DROP;
              end else if (ccnt == 11'd9) begin
                ncnt = '0;
                nst  = (len_q == '0) ? S_WKC : S_PAY;
              end
      S_PAY:  if (ccnt == len_q - 11'd1) begin
                ncnt = '0;
                nst  = S_WKC;
              end
      S_WKC:  if (ccnt == 11'd1) begin
                ncnt = '0;
                nst  = more_q ? S_DHDR : S_PASS;
              end
      default: ncnt = ccnt;
    endcase
    if (in_eof) begin
      nst  = S_ETH;
      ncnt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_ETH;
      cnt       <= '0;
      cmd_q     <= '0;
      len_lo_q  <= '0;
      off_q     <= '0;
      stn_q     <= '0;
      len_q     <= '0;
      et_hi_q   <= 1'b0;
      first_q   <= 1'b0;
      more_q    <= 1'b0;
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      brw_q     <= 1'b0;
      ptr_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_abort <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i) ^ 8'hA5;
    end else begin
      out_valid <= in_valid && (cst != S_DROP);
      out_data  <= obyte;
      out_sof   <= in_valid && in_sof;
      out_eof   <= in_valid && in_eof && (cst != S_DROP);
      out_abort <= in_valid && destroy;
      if (in_valid) begin
        st  <= nst;
        cnt <= ncnt;
        if (cst == S_ETH && ccnt == 11'd12) et_hi_q <= (in_data == ETYPE[15:8]);
        if (cst == S_FHDR) first_q <= 1'b1;
        if (cst == S_DHDR) begin
          case (ccnt)
            11'd0: cmd_q           <= in_data;
            11'd2: off_q[7:0]      <= in_data;
            11'd3: off_q[15:8]     <= in_data;
            11'd4: stn_q[7:0]      <= in_data;
            11'd5: stn_q[15:8]     <= in_data;
            11'd6: len_lo_q        <= in_data;
            11'd7: begin
              len_q  <= len_now;
              more_q <= in_data[7];
              rd_q   <= hit && cmd_q[0];
              wr_q   <= hit && cmd_q[1];
              ptr_q  <= off_q[PW-1:0];
            end
            default: ;
          endcase
        end
        if (in_pay) begin
          ptr_q <= ptr_q + 1'b1;
          if (wr_q) mem[ptr_q] <= in_data;
        end
        if (in_wkc0) brw_q   <= (in_data < {6'd0, dec});
        if (in_wkc1) first_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fbus_dgram_engine_chk.sv
module fbus_dgram_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_data,
  input logic       in_sof,
  input logic       in_eof,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       out_eof,
  input logic       out_abort
);
  AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R10
  AST_SOF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> $past(in_valid && in_sof)); // R10
  AST_SOF_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> (out_data == $past(in_data))); // R1
  AST_EOF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eof) |-> $past(in_valid && in_eof)); // R10
  AST_ABORT_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_abort |-> out_valid); // R8
  AST_ABORT_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_abort && !out_eof) |=> (!out_valid || out_sof)); // R8
endmodule

bind fbus_dgram_engine fbus_dgram_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_sof(in_sof), .in_eof(in_eof), .out_valid(out_valid), .out_data(out_data),
  .out_sof(out_sof), .out_eof(out_eof), .out_abort(out_abort)
);

// File: tb/fbus_dgram_engine_tb_top.sv
`timescale 1ns/1ps
module fbus_dgram_engine_tb_top;
  localparam logic [15:0] STATION = 16'h1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] station_addr = STATION;
  logic        main_port_open = 1'b1;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        out_valid, out_sof, out_eof, out_abort;
  logic [7:0]  out_data;

  logic [7:0] frm[$];
  logic [7:0] eo_q[$];
  bit         ev_q[$];
  bit         ea_q[$];
  logic [7:0] mm [256];

  logic       drv_v = 0, drv_sof = 0, drv_eof = 0, drv_ab = 0;
  logic [7:0] drv_d = '0;
  string      drv_tag = "R10";
  logic       exp_v = 0, exp_sof = 0, exp_eof = 0, exp_ab = 0;
  logic [7:0] exp_d = '0;
  string      exp_tag = "R10";
  int         checks = 0, fails = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  fbus_dgram_engine dut_i (
    .clk(clk), .rst_n(rst_n), .station_addr(station_addr), .main_port_open(main_port_open),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .out_abort(out_abort)
  );

  always @(posedge clk) begin
    exp_v   <= drv_v;
    exp_d   <= drv_d;
    exp_sof <= drv_sof;
    exp_eof <= drv_eof;
    exp_ab  <= drv_ab;
    exp_tag <= drv_tag;
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [11:0] act, expd;
      act  = {out_valid, out_valid ? {out_data, out_sof, out_eof, out_abort} : 11'd0};
      expd = {exp_v, exp_v ? {exp_d, exp_sof, exp_eof, exp_ab} : 11'd0};
      checks++;
      if (act !== expd) begin
        fails++;
        $display("FAIL %s: {valid,data,sof,eof,abort} actual %h expected %h", exp_tag, act, expd);
      end
    end
  end

  task automatic idle();
    in_valid = 0; in_sof = 0; in_eof = 0; in_data = '0;
    drv_v = 0; drv_sof = 0; drv_eof = 0; drv_ab = 0; drv_d = '0;
  endtask

  task automatic eth(logic [15:0] et);
    frm.delete();
    repeat (6) frm.push_back(8'hFF);
    frm.push_back(8'h02);
    repeat (4) frm.push_back(8'h00);
    frm.push_back(8'h01);
    frm.push_back(et[15:8]);
    frm.push_back(et[7:0]);
  endtask

  task automatic fhdr();
    frm.push_back(8'h40);
    frm.push_back(8'h10);
  endtask

  task automatic dg(int cmd, int off, int stn, int len, bit c, bit m, int wkc, int seed);
    frm.push_back(8'(cmd));
    frm.push_back(8'h07);
    frm.push_back(8'(off));
    frm.push_back(8'(off >> 8));
    frm.push_back(8'(stn));
    frm.push_back(8'(stn >> 8));
    frm.push_back(8'(len));
    frm.push_back(8'((len >> 8) & 7) | (c ? 8'h20 : 8'h00) | (m ? 8'h80 : 8'h00));
    frm.push_back(8'h00);
    frm.push_back(8'h00);
    for (int k = 0; k < len; k++) frm.push_back(8'(seed + 7 * k));
    frm.push_back(8'(wkc));
    frm.push_back(8'(wkc >> 8));
  endtask

  task automatic pad(int n);
    for (int k = 0; k < n; k++) frm.push_back(8'(8'hE0 + k));
  endtask

  task automatic model(bit open);
    int n, p, cmd, off, stn, len, w, wk, dec;
    bit first, hit, c, m;
    n = frm.size();
    eo_q = frm;
    ev_q.delete();
    ea_q.delete();
    for (int i = 0; i < n; i++) begin ev_q.push_back(1); ea_q.push_back(0); end
    if (n < 16 || frm[12] != 8'h88 || frm[13] != 8'hA4) return;
    p = 16;
    first = 1;
    while (p + 10 <= n) begin
      cmd = frm[p];
      off = frm[p+2] + 256 * frm[p+3];
      stn = frm[p+4] + 256 * frm[p+5];
      len = frm[p+6] + 256 * (frm[p+7] & 8'h07);
      c = frm[p+7][5];
      m = frm[p+7][7];
      if (first && !open) begin
        if (c) begin
          ea_q[p+7] = 1;
          for (int k = p + 8; k < n; k++) ev_q[k] = 0;
          return;
        end
        eo_q[p+7] = frm[p+7] | 8'h20;
      end
      hit = open && stn == STATION && cmd >= 1 && cmd <= 3 && off + len <= 256;
      dec = hit ? ((cmd & 1) * 2 + ((cmd >> 1) & 1)) : 0;
      for (int k = 0; k < len; k++) begin
        if (hit && (cmd & 1)) eo_q[p+10+k] = mm[off+k];
        if (hit && (cmd & 2)) mm[off+k] = frm[p+10+k];
      end
      w  = p + 10 + len;
      wk = (frm[w] + 256 * frm[w+1] - dec) & 16'hFFFF;
      eo_q[w]   = 8'(wk);
      eo_q[w+1] = 8'(wk >> 8);
      if (!m) break;
      p = w + 2;
      first = 0;
    end
  endtask

  task automatic send(string tag, int gap);
    model(main_port_open);
    for (int i = 0; i < frm.size(); i++) begin
      @(posedge clk); #1;
      in_valid = 1; in_data = frm[i];
      in_sof = (i == 0); in_eof = (i == frm.size() - 1);
      drv_v = ev_q[i]; drv_d = eo_q[i]; drv_sof = in_sof; drv_eof = in_eof;
      drv_ab = ea_q[i]; drv_tag = tag;
      if (gap > 0 && i % 3 == 1) begin
        for (int g = 0; g < gap; g++) begin @(posedge clk); #1; idle(); end
      end
    end
    @(posedge clk); #1;
    idle();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mm[i] = 8'(i) ^ 8'hA5;
    repeat (3) @(negedge clk);
    checks++;
    if ({out_valid, out_sof, out_eof, out_abort, out_data} !== 12'd0) begin
      fails++;
      $display("FAIL R9: reset outputs actual %h expected 000",
               {out_valid, out_sof, out_eof, out_abort, out_data});
    end
    @(posedge clk); #1; rst_n = 1;
    repeat (2) @(posedge clk); #1;

    eth(16'h88A4); fhdr(); dg(1, 0, STATION, 4, 0, 0, 5, 0);        send("R9 reset array", 0);
    eth(16'h0800); pad(50);                                           send("R1", 0);
    eth(16'h88A4); fhdr(); dg(2, 16'h10, STATION, 6, 0, 0, 3, 8'h31); send("R2 R3 R5 write", 0);
    eth(16'h88A4); fhdr(); dg(1, 16'h10, STATION, 6, 0, 0, 9, 0);     send("R3 read", 0);
    eth(16'h88A4); fhdr(); dg(3, 16'h12, STATION, 3, 0, 0, 16, 8'h90); send("R3 R5 readwrite", 0);
    eth(16'h88A4); fhdr();
      dg(1, 16'h10, 16'h1235, 4, 0, 1, 7, 1);
      dg(1, 16'hFA, STATION, 8, 0, 1, 7, 2);
      dg(2, 16'h100, STATION, 1, 0, 1, 7, 3);
      dg(1, 16'hF8, STATION, 8, 0, 0, 7, 4);                          send("R4", 0);
    eth(16'h88A4); fhdr();
      dg(0, 16'h10, STATION, 4, 0, 1, 7, 5);
      dg(9, 16'h10, STATION, 4, 0, 0, 7, 6);                          send("R3 other cmds", 0);
    eth(16'h88A4); fhdr();
      dg(2, 16'h20, 16'h0042, 3, 0, 1, 1, 7);
      dg(2, 16'h20, STATION, 3, 0, 1, 1, 8'h50);
      dg(1, 16'h20, STATION, 0, 0, 0, 1, 0);
      pad(10);                                                        send("R6", 0);
    eth(16'h88A4); fhdr();
      dg(1, 16'h30, STATION, 2, 0, 1, 16'h0100, 0);
      dg(1, 16'h30, STATION, 2, 0, 1, 16'h0000, 0);
      dg(3, 16'h30, STATION, 2, 0, 0, 16'h0002, 8'h11);               send("R5 borrow", 0);
    main_port_open = 0;
    eth(16'h88A4); fhdr();
      dg(1, 16'h10, STATION, 4, 0, 1, 5, 0);
      dg(2, 16'h10, STATION, 4, 1, 0, 5, 8'h77);                      send("R7", 0);
    eth(16'h88A4); fhdr(); dg(2, 16'h40, STATION, 4, 1, 0, 5, 8'h66); pad(6); send("R8 destroy", 0);
    main_port_open = 1;
    eth(16'h88A4); fhdr(); dg(1, 16'h40, STATION, 4, 0, 0, 5, 0);     send("R8 next frame", 0);
    eth(16'h88A4); fhdr(); dg(3, 16'h50, STATION, 5, 0, 0, 4, 8'h21); send("R10 gaps", 2);
    eth(16'h88A4); fhdr(); dg(1, 16'h50, STATION, 5, 0, 0, 4, 0);     send("R10 back to back", 0);
    repeat (4) @(posedge clk);
    #1;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R10: watchdog expired, actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule